// File: doc/BRIEF.md
# Indirect Indexed Address Sequencer

This block sequences the bus for an 8-bit processor instruction that uses zero-page indirect, Y-indexed addressing. A start strobe is given together with the program counter of the opcode. The block then drives one bus access per clock. It reads the opcode, reads the pointer byte, and reads a two-byte base address from zero page at that pointer. It adds the Y index to the low byte and then performs the data access.

The first data access goes out before the high byte has been corrected. A read whose index add carries out of the low byte repeats the access at the corrected address in a sixth cycle. A read with no carry completes in five cycles. A store always uses six cycles: cycle five is a dummy read at the uncorrected address, and cycle six writes to the corrected address.

A done pulse marks the final bus cycle and reports the cycle count. The read value is held in a register from the following clock onward.

Top module: `ziy_addr_seq`

## Requirements
- R1: A synchronous reset puts the block in idle. While idle, `done` is 0, `bus_we` is 0, `cyc_total` is 0 and `bus_addr` is 0. A reset asserted in the middle of an operation abandons that operation.
- R2: In the first cycle after an accepted start, the block reads at the PC. In the second cycle it reads at PC+1. After the operation, `pc_next` equals PC+2 (mod 2^16).
- R3: Cycle 3 reads at {8'h00, ptr}, where ptr is the byte read in cycle 2. Cycle 4 reads at {8'h00, (ptr+1) mod 256}, so the pointer never leaves zero page.
- R4: Cycle 5 reads at {hi, (lo+Y) mod 256}. Here lo is the byte read in cycle 3 and hi is the byte read in cycle 4, with no correction for carry.
- R5: For a read (`is_store`=0) where lo+Y < 256, cycle 5 is the final cycle. `done`=1 and `cyc_total`=5 in that cycle, and `rd_value` then holds the byte read in cycle 5.
- R6: For a read where lo+Y >= 256, cycle 6 reads at {(hi+1) mod 256, (lo+Y) mod 256}. It is the final cycle with `cyc_total`=6, and `rd_value` then holds the cycle-6 byte.
- R7: A store (`is_store`=1) always takes 6 cycles. Cycle 5 is a read at the uncorrected address. Cycle 6 writes the store data latched at start to {(hi+carry) mod 256, (lo+Y) mod 256}. A store leaves `rd_value` unchanged.
- R8: `bus_we`=1 only in the final cycle of a store. Every other bus cycle of an operation is a read.
- R9: `done` is high for exactly one clock per operation.
- R10: A start strobe given while an operation is in progress is ignored. The access sequence, the cycle count and the number of done pulses are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| is_store | input | 1 | Operation class: 0 read, 1 store; latched at start |
| pc_in | input | 16 | Address of the opcode; latched at start |
| y_idx | input | 8 | Y index; latched at start |
| st_data | input | 8 | Store data; latched at start |
| mem_rdata | input | 8 | Memory read data for the current bus address, same cycle |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write data |
| rd_value | output | 8 | Last captured read data |
| done | output | 1 | High in the final bus cycle |
| cyc_total | output | 3 | Cycle count (5 or 6) while done is high, else 0 |
| pc_next | output | 16 | PC after the opcode and operand fetches |

## Verification
The bench builds the block with the default 8-bit data width, which makes every Y value reachable. It sweeps all 256 indices against low bytes chosen at and around the carry boundary (00, 01, 7F, 80, FE, FF), for both classes. The pointer follows the index, so the 0xFF pointer wrap is covered, and a high byte of 0xFF exercises the wrap of the corrected page. Some runs also inject a start strobe during an operation, and one run asserts reset in the middle of an operation.

// File: rtl/ziy_pkg.sv
package ziy_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_OPC  = 3'd1,
      S_PTR  = 3'd2,
      S_LO   = 3'd3,
      S_HI   = 3'd4,
      S_DATA = 3'd5,
      S_FIX  = 3'd6
   } ziy_state_e;
endpackage

// File: rtl/ziy_index_add.sv
module ziy_index_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] base_lo,
   input  logic [W-1:0] idx,
   input  logic [W-1:0] page_hi,
   input  logic         carry_in,
   output logic [W-1:0] sum_lo,
   output logic         carry_out,
   output logic [W-1:0] page_fixed
);
   logic [W:0] wide_sum;
   logic [W:0] inc_chain;

   initial begin
      if (W < 2) $error("ziy_index_add: W must be at least 2");
   end

   assign wide_sum  = {1'b0, base_lo} + {1'b0, idx};
   assign sum_lo    = wide_sum[W-1:0];
   assign carry_out = wide_sum[W];

   // page fix-up: increment by exactly one when the latched carry is set
   assign inc_chain[0] = carry_in;
   for (genvar i = 0; i < W; i++) begin : g_inc
      assign page_fixed[i]  = page_hi[i] ^ inc_chain[i];
      assign inc_chain[i+1] = page_hi[i] & inc_chain[i];
   end
endmodule

// File: rtl/ziy_seq_ctrl.sv
module ziy_seq_ctrl
   import ziy_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       store_q,
   input  logic       carry_q,
   output ziy_state_e state,
   output logic       done,
   output logic       long_op
);
   ziy_state_e state_d;

   assign long_op = store_q | carry_q;
   assign done    = (state == S_FIX) || (state == S_DATA && !long_op);

   always_comb begin
      state_d = state;
      case (state)
         S_IDLE:  if (start) state_d = S_OPC;
         S_OPC:   state_d = S_PTR;
         S_PTR:   state_d = S_LO;
         S_LO:    state_d = S_HI;
         S_HI:    state_d = S_DATA;
         S_DATA:  state_d = long_op ? S_FIX : S_IDLE;
         S_FIX:   state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S_IDLE;
      else     state <= state_d;
   end

   a_r1_reset_idle: assert property (@(posedge clk) rst |=> state == S_IDLE);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   a_r5_read_short: assert property (@(posedge clk) disable iff (rst)
      (state == S_DATA && !store_q && !carry_q) |=> state == S_IDLE);
   a_r7_store_long: assert property (@(posedge clk) disable iff (rst)
      (state == S_DATA && store_q) |=> state == S_FIX);
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
      (state == S_FIX) |=> state == S_IDLE);
endmodule

// File: rtl/ziy_addr_seq.sv
module ziy_addr_seq
   import ziy_pkg::*;
#(
   parameter  int DATA_W = 8,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              is_store,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] y_idx,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_value,
   output logic              done,
   output logic [2:0]        cyc_total,
   output logic [ADDR_W-1:0] pc_next
);
   localparam logic [DATA_W-1:0] ZP_PAGE = '0;

   ziy_state_e        state;
   logic              long_op;
   logic [ADDR_W-1:0] pc_q, pcn_q;
   logic [DATA_W-1:0] y_q, st_q, ptr_q, lo_q, hi_q, sum_q, fixhi_q, rd_q;
   logic              store_q, carry_q;
   logic [DATA_W-1:0] sum_c, fixed_c;
   logic              carry_c;
   logic [DATA_W-1:0] ptr_inc;

   initial begin
      if (DATA_W < 2) $error("ziy_addr_seq: DATA_W must be at least 2");
   end

   ziy_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .store_q (store_q),
      .carry_q (carry_q),
      .state   (state),
      .done    (done),
      .long_op (long_op)
   );

   ziy_index_add #(.W(DATA_W)) u_add (
      .base_lo    (lo_q),
      .idx        (y_q),
      .page_hi    (hi_q),
      .carry_in   (carry_q),
      .sum_lo     (sum_c),
      .carry_out  (carry_c),
      .page_fixed (fixed_c)
   );

   assign ptr_inc = ptr_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         pcn_q   <= '0;
         y_q     <= '0;
         st_q    <= '0;
         store_q <= 1'b0;
         ptr_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         sum_q   <= '0;
         carry_q <= 1'b0;
         fixhi_q <= '0;
         rd_q    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               pc_q    <= pc_in;
               y_q     <= y_idx;
               st_q    <= st_data;
               store_q <= is_store;
               carry_q <= 1'b0;
            end
            S_OPC: pc_q <= pc_q + 1'b1;
            S_PTR: begin
               ptr_q <= mem_rdata;
               pc_q  <= pc_q + 1'b1;
               pcn_q <= pc_q + 1'b1;
            end
            S_LO: lo_q <= mem_rdata;
            S_HI: begin
               hi_q    <= mem_rdata;
               sum_q   <= sum_c;
               carry_q <= carry_c;
            end
            S_DATA: begin
               fixhi_q <= fixed_c;
               if (!long_op) rd_q <= mem_rdata;
            end
            S_FIX: if (!store_q) rd_q <= mem_rdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_addr = '0;
      bus_we   = 1'b0;
      case (state)
         S_OPC:   bus_addr = pc_q;
         S_PTR:   bus_addr = pc_q;
         S_LO:    bus_addr = {ZP_PAGE, ptr_q};
         S_HI:    bus_addr = {ZP_PAGE, ptr_inc};
         S_DATA:  bus_addr = {hi_q, sum_q};
         S_FIX: begin
            bus_addr = {fixhi_q, sum_q};
            bus_we   = store_q;
         end
         default: ;
      endcase
   end

   assign bus_wdata = st_q;
   assign rd_value  = rd_q;
   assign pc_next   = pcn_q;
   assign cyc_total = !done ? 3'd0 : (state == S_FIX ? 3'd6 : 3'd5);

   a_r8_we_final: assert property (@(posedge clk) disable iff (rst)
      bus_we |-> (done && cyc_total == 3'd6));
   a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
      (state == S_HI) |-> bus_addr == {ZP_PAGE, $past(bus_addr[DATA_W-1:0]) + 1'b1});
   a_r6_fix_addr: assert property (@(posedge clk) disable iff (rst)
      (state == S_FIX) |-> bus_addr ==
         {$past(bus_addr[ADDR_W-1:DATA_W]) + DATA_W'(carry_q), $past(bus_addr[DATA_W-1:0])});
   a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
      (state == S_PTR) |-> bus_addr == $past(bus_addr) + 1'b1);
endmodule

// File: tb/ziy_addr_seq_tb.sv
module ziy_addr_seq_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        is_store = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  y_idx = '0;
   logic [7:0]  st_data = '0;
   logic [7:0]  mem_rdata;
   logic [15:0] bus_addr;
   logic        bus_we;
   logic [7:0]  bus_wdata;
   logic [7:0]  rd_value;
   logic        done;
   logic [2:0]  cyc_total;
   logic [15:0] pc_next;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit ended   = 1'b0;

   // memory image held as a few bench registers plus a hash elsewhere
   logic [15:0] t_pc;
   logic [7:0]  t_ptr, t_lo, t_hi;
   logic [7:0]  last_rd = '0;

   always #5 clk = ~clk;

   ziy_addr_seq u_dut (
      .clk(clk), .rst(rst), .start(start), .is_store(is_store), .pc_in(pc_in),
      .y_idx(y_idx), .st_data(st_data), .mem_rdata(mem_rdata), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .rd_value(rd_value), .done(done),
      .cyc_total(cyc_total), .pc_next(pc_next)
   );

   function automatic logic [7:0] mem_at(input logic [15:0] a);
      if (a == t_pc)                      return 8'h91;
      if (a == t_pc + 16'd1)              return t_ptr;
      if (a == {8'h00, t_ptr})            return t_lo;
      if (a == {8'h00, t_ptr + 8'd1})     return t_hi;
      return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
   endfunction

   assign mem_rdata = mem_at(bus_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         finish_run();
      end
   end

   task automatic run_op(input bit st, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] y, input logic [7:0] ptr, input bit poke);
      logic [8:0]  wsum;
      logic [7:0]  sum8, fixh;
      logic        cy;
      int          total;
      logic [15:0] exp_a;
      logic [7:0]  exp_rd;
      t_pc  = 16'hC000 + {6'd0, y, 2'd0};
      t_ptr = ptr; t_lo = lo; t_hi = hi;
      wsum  = {1'b0, lo} + {1'b0, y};
      sum8  = wsum[7:0];
      cy    = wsum[8];
      fixh  = hi + {7'd0, cy};
      total = (st || cy) ? 6 : 5;
      exp_rd = last_rd;
      @(negedge clk);
      start = 1'b1; is_store = st; pc_in = t_pc; y_idx = y; st_data = y ^ 8'h3C;
      @(negedge clk);
      start = 1'b0; is_store = ~st; y_idx = ~y; st_data = 8'h00;
      for (int k = 1; k <= total; k++) begin
         case (k)
            1: exp_a = t_pc;
            2: exp_a = t_pc + 16'd1;
            3: exp_a = {8'h00, ptr};
            4: exp_a = {8'h00, ptr + 8'd1};
            5: exp_a = {hi, sum8};
            default: exp_a = {fixh, sum8};
         endcase
         if (k <= 2)      chk(bus_addr == exp_a, "R2 fetch addr", bus_addr, exp_a);
         else if (k <= 4) chk(bus_addr == exp_a, "R3 zp pointer addr", bus_addr, exp_a);
         else if (k == 5) chk(bus_addr == exp_a, "R4 uncorrected addr", bus_addr, exp_a);
         else if (st)     chk(bus_addr == exp_a, "R7 store corrected addr", bus_addr, exp_a);
         else             chk(bus_addr == exp_a, "R6 read corrected addr", bus_addr, exp_a);
         chk(bus_we == (st && k == 6), "R8 write strobe", bus_we, st && k == 6);
         chk(done == (k == total), "R9 done timing", done, k == total);
         if (k == total) begin
            chk(cyc_total == 3'(total), st ? "R7 store count" : (cy ? "R6 count" : "R5 count"),
                cyc_total, total);
            if (st) chk(bus_wdata == (y ^ 8'h3C), "R7 write data", bus_wdata, y ^ 8'h3C);
            else    exp_rd = mem_at(exp_a);
         end
         if (poke && k == 2) start = 1'b1;
         if (k == 3) start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      chk(rd_value == exp_rd, st ? "R7 rd unchanged" : (cy ? "R6 rd data" : "R5 rd data"),
          rd_value, exp_rd);
      chk(pc_next == t_pc + 16'd2, "R2 pc_next", pc_next, t_pc + 16'd2);
      chk(done == 1'b0 && bus_we == 1'b0, poke ? "R10 no restart" : "R9 done low after",
          {done, bus_we}, 0);
      chk(bus_addr == 16'd0, poke ? "R10 idle after poke" : "R1 idle addr", bus_addr, 0);
      last_rd = exp_rd;
   endtask

   initial begin
      logic [7:0] lo_set [6];
      lo_set = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
      t_pc = 16'hC000; t_ptr = 8'h33; t_lo = 8'h00; t_hi = 8'h00;
      repeat (3) @(negedge clk);
      chk(done == 0 && bus_we == 0 && cyc_total == 0 && bus_addr == 0, "R1 reset state",
          {done, bus_we, cyc_total, bus_addr}, 0);
      rst = 1'b0;
      // reset in the middle of an operation
      @(negedge clk);
      start = 1'b1; is_store = 1'b1; pc_in = 16'hC000; y_idx = 8'hF0;
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(done == 0 && bus_we == 0 && bus_addr == 0, "R1 mid-op reset",
          {done, bus_we, bus_addr}, 0);
      repeat (2) @(negedge clk);
      chk(bus_addr == 0 && done == 0, "R1 stays idle", bus_addr, 0);
      // sweep
      for (int s = 0; s < 2; s++) begin
         for (int li = 0; li < 6; li++) begin
            for (int yy = 0; yy < 256; yy++) begin
               logic [7:0] hv;
               hv = (yy % 3 == 0) ? 8'hFF : (8'(yy) ^ 8'h5A);
               run_op(s[0], lo_set[li], hv, 8'(yy), 8'(yy), (yy % 7) == 0);
            end
         end
      end
      finish_run();
   end
endmodule